// File: doc/BRIEF.md
# Zero-turnaround late-write synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose data bus can carry a read, then a write, then a read on consecutive clock cycles with no idle cycle between them. The memory samples the command, the address, the chip enables and the byte-write enables on a rising edge. The data for that command moves a fixed number of enabled edges later. Write data is delayed by the same amount as read data, so the data bus never has to turn around. A static mode input picks one of two timings. The pipelined timing has a two-edge data phase and a registered output. The flow-through timing has a one-edge data phase.

A burst sequencer is built in. A load command stores a start address. Each advance command steps a 2-bit beat counter and continues the last operation. The beat counter walks the low two address bits in either linear or interleaved order. The block also has a clock enable that freezes every stage, 9-bit byte lanes with individual write enables, a decode of three chip enables, and a sleep input. During sleep the block refuses new commands and keeps the memory contents. The read data is given as a value plus a drive flag, which stands in for a tri-state bus. An output-enable input masks that drive flag combinationally.

Top module: `lw_sram`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, rdata_en is 0 and rdata is 0.
- R2: With flow_mode=0, a read command sampled at enabled edge k drives its data on rdata, with rdata_en=1, from just after enabled edge k+2 until the next enabled edge. A write command sampled at enabled edge k takes its data from wdata at enabled edge k+2.
- R3: With flow_mode=1, the same rules as R2 hold with a delay of one enabled edge in place of two.
- R4: Any sequence of reads and writes may be issued on consecutive edges with no idle cycle. A read always returns the data of every write issued before it, including a write issued on the immediately preceding edge to the same address.
- R5: A word is 2 lanes of 9 bits each. Setting byte_en bit i writes wdata bits [9i+8:9i]. A lane whose enable bit is 0 keeps its old contents.
- R6: A write with byte_en=0 changes no memory location.
- R7: The device is selected only when ce1, ce2 and ce3 are all 1. A load command with any other pattern neither reads nor writes, and it leaves rdata_en at 0 in its data cycle.
- R8: adv_ld=0 loads a new start address and begins a new burst, and its beat index is 0. adv_ld=1 increments the beat index and accesses the next burst address. An advance repeats the operation of the last load and ignores we, addr and the chip enables, but it takes its own byte_en. An advance after a deselecting load does nothing.
- R9: The address of beat n keeps the upper address bits of the start address. With burst_ilv=0 its low two bits are (start[1:0] + n) mod 4. With burst_ilv=1 they are start[1:0] XOR n.
- R10: On a cycle with clk_en=0 the block samples no command and no write data, moves no pipeline stage or burst state, and holds rdata and rdata_en.
- R11: If sleep is first sampled high at edge a, commands sampled at edges a and a+1 are still carried out, and commands from edge a+2 on are ignored. If sleep is first sampled low again at edge b, commands at edges b and b+1 are ignored and commands from edge b+2 on are carried out. The memory contents are kept throughout.
- R12: rdata_en is 1 only in the data cycle of a read, and only while oe=1 and the block is not asleep. When rdata_en is 0, rdata is 0. oe acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| clk_en | input | 1 | Clock enable; 0 freezes the whole block |
| ce1 | input | 1 | Chip enable 1, active high |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3 | input | 1 | Chip enable 3, active high |
| we | input | 1 | 1 = write, 0 = read; sampled on load commands only |
| adv_ld | input | 1 | 0 = load a start address, 1 = advance the burst |
| byte_en | input | 2 | Byte-lane write enables |
| addr | input | 4 | Word address |
| wdata | input | 18 | Late write data |
| flow_mode | input | 1 | 0 = pipelined timing, 1 = flow-through timing; change it only during reset |
| burst_ilv | input | 1 | 0 = linear burst order, 1 = interleaved burst order |
| oe | input | 1 | Output enable; combinational mask on the read drive |
| sleep | input | 1 | Sleep request |
| rdata | output | 18 | Read data; 0 when not driven |
| rdata_en | output | 1 | 1 when rdata is driven |

## Verification
The bench runs the same set of patterns under both timings, with a reset between them.

- **Full sweeps.** A write to every address followed by a read of every address sets the data latency of each timing apart.
- **Write-then-read pairs.** Each write is followed at once by a read of the same word and a read of an unrelated word. This separates a correct forwarding path for data still in flight from a read of the stale array.
- **Byte-lane patterns.** Every byte-enable pattern, including the empty one, shows per-lane merging and the write abort.
- **Deselects.** Every non-selecting chip-enable pattern shows that a deselect does nothing.
- **Bursts.** Write bursts from each start offset, in both orders, with junk on the ignored inputs, are read back with single loads. Because a burst is not read back with a burst, a wrong beat order cannot cancel itself out.
- **Stalls.** Stall cycles inside a mixed stream carry conflicting inputs and show that the freeze holds all state.
- **Sleep.** The sleep test places an accepted write on the last edge before power-down. It then issues rejected commands while the block is asleep and checks that the memory contents survive.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int unsigned LW_ADDR_W  = 4;
    localparam int unsigned LW_LANES   = 2;
    localparam int unsigned LW_LANE_W  = 9;
    localparam int unsigned LW_BURST_W = 2;
    localparam int unsigned LW_DATA_W  = LW_LANES * LW_LANE_W;
    localparam int unsigned LW_DEPTH   = 1 << LW_ADDR_W;

    typedef logic [LW_ADDR_W-1:0]  addr_t;
    typedef logic [LW_DATA_W-1:0]  data_t;
    typedef logic [LW_LANES-1:0]   be_t;
    typedef logic [LW_BURST_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // One accepted access travelling down the data pipeline
    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
        be_t   be;
    } cmd_t;

    // Address of a burst beat: upper bits kept, low bits stepped
    function automatic addr_t beat_addr(addr_t base, beat_t step, logic ilv);
        beat_t lo;
        if (ilv) begin
            lo = base[LW_BURST_W-1:0] ^ step;
        end else begin
            lo = beat_t'(base[LW_BURST_W-1:0] + step);
        end
        return {base[LW_ADDR_W-1:LW_BURST_W], lo};
    endfunction

endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
    import lw_sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clk_en,
    input  logic  block,
    input  logic  sel,
    input  logic  we,
    input  logic  adv,
    input  logic  ilv,
    input  be_t   be,
    input  addr_t addr,
    output cmd_t  cmd
);

    typedef struct packed {
        addr_t base;
        beat_t step;
        op_e   last;
    } seq_t;

    seq_t  seq_q, seq_d;
    beat_t step_nx;
    addr_t beat_a;

    assign step_nx = seq_q.step + beat_t'(1);
    assign beat_a  = beat_addr(seq_q.base, step_nx, ilv);

    always_comb begin
        seq_d = seq_q;
        cmd   = '0;
        if (!block) begin
            if (!adv) begin
                if (sel) begin
                    seq_d.base = addr;
                    seq_d.step = '0;
                    seq_d.last = we ? OP_WR : OP_RD;
                    cmd.addr   = addr;
                    cmd.be     = be;
                    cmd.rd     = !we;
                    cmd.wr     = we && (|be);
                end else begin
                    seq_d.last = OP_NONE;
                end
            end else if (seq_q.last != OP_NONE) begin
                seq_d.step = step_nx;
                cmd.addr   = beat_a;
                cmd.be     = be;
                cmd.rd     = (seq_q.last == OP_RD);
                cmd.wr     = (seq_q.last == OP_WR) && (|be);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{base: '0, step: '0, last: OP_NONE};
        end else if (clk_en) begin
            seq_q <= seq_d;
        end
    end

    // Every live advance steps the beat index by exactly one
    p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !block && adv && seq_q.last != OP_NONE)
        |=> (seq_q.step == beat_t'($past(seq_q.step) + beat_t'(1))));

    // A frozen clock leaves the burst state untouched
    p_burst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(seq_q));

endmodule

// File: rtl/lw_sram_doze.sv
module lw_sram_doze (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic asleep
);

    typedef struct packed {
        logic seen;
        logic down;
    } doze_t;

    doze_t doze_q, doze_d;

    always_comb begin
        doze_d.seen = sleep;
        doze_d.down = doze_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            doze_q <= '0;
        end else begin
            doze_q <= doze_d;
        end
    end

    assign asleep = doze_q.down;

    p_sleep_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep, 2));

    p_sleep_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> !$past(sleep, 2));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
(
    input  logic  clk,
    input  logic  wen,
    input  addr_t waddr,
    input  be_t   wbe,
    input  data_t wdata,
    input  addr_t raddr,
    output data_t rdata
);

    for (genvar g = 0; g < LW_LANES; g++) begin : g_lane
        logic [LW_LANE_W-1:0] mem [LW_DEPTH];

        always_ff @(posedge clk) begin
            if (wen && wbe[g]) begin
                mem[waddr] <= wdata[g*LW_LANE_W +: LW_LANE_W];
            end
        end

        assign rdata[g*LW_LANE_W +: LW_LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 ce1,
    input  logic                 ce2,
    input  logic                 ce3,
    input  logic                 we,
    input  logic                 adv_ld,
    input  logic [LW_LANES-1:0]  byte_en,
    input  logic [LW_ADDR_W-1:0] addr,
    input  logic [LW_DATA_W-1:0] wdata,
    input  logic                 flow_mode,
    input  logic                 burst_ilv,
    input  logic                 oe,
    input  logic                 sleep,
    output logic [LW_DATA_W-1:0] rdata,
    output logic                 rdata_en
);

    typedef struct packed {
        cmd_t  st1;     // accepted on the last enabled edge
        cmd_t  st2;     // one enabled edge older (pipelined timing only)
        data_t rd2;     // early array read for st2 (pipelined timing only)
        data_t out;     // output register
        logic  out_vld;
    } pipe_t;

    pipe_t pipe_q, pipe_d;
    logic  asleep;
    logic  selected;
    cmd_t  cmd_new;
    cmd_t  wr_st;
    logic  arr_we;
    data_t arr_rd;
    data_t merged;

    assign selected = ce1 && ce2 && ce3;

    lw_sram_doze u_doze (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .asleep (asleep)
    );

    lw_sram_burst u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .block  (asleep),
        .sel    (selected),
        .we     (we),
        .adv    (adv_ld),
        .ilv    (burst_ilv),
        .be     (byte_en),
        .addr   (addr),
        .cmd    (cmd_new)
    );

    // The write commits at the edge where its late data is on wdata
    assign wr_st  = flow_mode ? pipe_q.st1 : pipe_q.st2;
    assign arr_we = clk_en && wr_st.wr;

    lw_sram_array u_array (
        .clk   (clk),
        .wen   (arr_we),
        .waddr (wr_st.addr),
        .wbe   (wr_st.be),
        .wdata (wdata),
        .raddr (pipe_q.st1.addr),
        .rdata (arr_rd)
    );

    always_comb begin
        pipe_d = pipe_q;

        // Forward lanes of the write committing on this same edge
        for (int i = 0; i < LW_LANES; i++) begin
            if (pipe_q.st2.wr && pipe_q.st2.be[i]
                && (pipe_q.st2.addr == pipe_q.st1.addr)) begin
                merged[i*LW_LANE_W +: LW_LANE_W] = wdata[i*LW_LANE_W +: LW_LANE_W];
            end else begin
                merged[i*LW_LANE_W +: LW_LANE_W] = arr_rd[i*LW_LANE_W +: LW_LANE_W];
            end
        end

        if (clk_en) begin
            pipe_d.st1 = cmd_new;
            if (flow_mode) begin
                pipe_d.st2     = '0;
                pipe_d.rd2     = '0;
                pipe_d.out     = arr_rd;
                pipe_d.out_vld = pipe_q.st1.rd;
            end else begin
                pipe_d.st2     = pipe_q.st1;
                pipe_d.rd2     = merged;
                pipe_d.out     = pipe_q.rd2;
                pipe_d.out_vld = pipe_q.st2.rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rdata_en = oe && pipe_q.out_vld && !asleep;
    assign rdata    = rdata_en ? pipe_q.out : '0;

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pipe_q));

    p_drive_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> (oe && !asleep));

    p_sleep_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && asleep) |=> !(pipe_q.st1.rd || pipe_q.st1.wr));

    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !asleep && !adv_ld && !selected)
        |=> !(pipe_q.st1.rd || pipe_q.st1.wr));

    p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !flow_mode && pipe_q.st2.rd) |=> pipe_q.out_vld);

    p_pipe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !flow_mode && pipe_q.st1.wr) |=> pipe_q.st2.wr);

    p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && flow_mode && pipe_q.st1.rd) |=> pipe_q.out_vld);

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;
    import lw_sram_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en, ce1, ce2, ce3, we, adv_ld;
    logic [1:0]  byte_en;
    logic [3:0]  addr;
    logic [17:0] wdata;
    logic        flow_mode, burst_ilv, oe, sleep;
    logic [17:0] rdata;
    logic        rdata_en;

    always #2 clk = ~clk;

    lw_sram u_lw_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ce1       (ce1),
        .ce2       (ce2),
        .ce3       (ce3),
        .we        (we),
        .adv_ld    (adv_ld),
        .byte_en   (byte_en),
        .addr      (addr),
        .wdata     (wdata),
        .flow_mode (flow_mode),
        .burst_ilv (burst_ilv),
        .oe        (oe),
        .sleep     (sleep),
        .rdata     (rdata),
        .rdata_en  (rdata_en)
    );

    int checks = 0;
    int fails = 0;
    int n = 0;
    int done_idx = -100;
    int lat = 2;
    bit last_cke = 1'b1;
    bit finished = 1'b0;

    logic [17:0] refm [16];
    bit          rv   [4096];
    logic [17:0] rexp [4096];
    bit          wv   [4096];
    logic [17:0] wdq  [4096];
    string       tg   [4096];

    logic [3:0] bbase;
    logic [1:0] bstep;
    int         blast;
    logic       prev_en;
    logic [17:0] prev_d;
    string      cur_tag = "R1";
    bit         oe_v = 1'b1, ilv_v = 1'b0, slp_v = 1'b0;

    function automatic logic [3:0] beat(logic [3:0] b, logic [1:0] c, bit ilv);
        logic [1:0] lo;
        lo = ilv ? (b[1:0] ^ c) : 2'(b[1:0] + c);
        return {b[3:2], lo};
    endfunction

    function automatic logic [17:0] pat(int a, int seed);
        return 18'((a * 18'h1111) + 18'h0A5 + (seed * 18'h2345));
    endfunction

    task automatic check(string req, logic [18:0] act, logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic out_check();
        logic [18:0] e;
        string t;
        int m;
        if (last_cke) begin
            m = done_idx - lat;
            if (m >= 0 && rv[m] && oe) begin
                e = {1'b1, rexp[m]};
                t = tg[m];
            end else begin
                e = '0;
                t = (m >= 0 && rv[m]) ? "R12 oe low" : "R12 not driven";
            end
        end else begin
            e = {prev_en, prev_d};
            t = "R10 stall hold";
        end
        check(t, {rdata_en, rdata}, e);
        prev_en = rdata_en;
        prev_d  = rdata;
    endtask

    task automatic cyc(bit cke, bit [2:0] ces, bit we_i, bit adv_i, bit [1:0] be_i,
                       bit [3:0] a_i, bit [17:0] d_i, bit blk);
        int op;
        logic [3:0] ea;
        @(negedge clk);
        out_check();
        clk_en = cke;
        {ce1, ce2, ce3} = ces;
        we = we_i;
        adv_ld = adv_i;
        byte_en = be_i;
        addr = a_i;
        oe = oe_v;
        burst_ilv = ilv_v;
        sleep = slp_v;
        wdata = 18'h3FFFF ^ 18'(n * 37);
        if (cke && n >= lat && wv[n-lat]) wdata = wdq[n-lat];
        if (cke) begin
            op = 0;
            ea = a_i;
            if (!blk) begin
                if (!adv_i) begin
                    if (ces == 3'b111) begin
                        bbase = a_i;
                        bstep = 2'd0;
                        blast = we_i ? 2 : 1;
                        op = blast;
                    end else begin
                        blast = 0;
                    end
                end else if (blast != 0) begin
                    bstep = bstep + 2'd1;
                    ea = beat(bbase, bstep, ilv_v);
                    op = blast;
                end
            end
            rv[n] = (op == 1);
            wv[n] = (op == 2) && (be_i != 2'b00);
            tg[n] = cur_tag;
            if (op == 1) rexp[n] = refm[ea];
            if (wv[n]) begin
                wdq[n] = d_i;
                if (be_i[0]) refm[ea][8:0]  = d_i[8:0];
                if (be_i[1]) refm[ea][17:9] = d_i[17:9];
            end
            done_idx = n;
            n++;
        end
        last_cke = cke;
    endtask

    task automatic wr(bit [3:0] a, bit [17:0] d, bit [1:0] be);
        cyc(1'b1, 3'b111, 1'b1, 1'b0, be, a, d, 1'b0);
    endtask

    task automatic rd(bit [3:0] a);
        cyc(1'b1, 3'b111, 1'b0, 1'b0, 2'b11, a, 18'h0, 1'b0);
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cyc(1'b1, 3'b000, 1'b0, 1'b0, 2'b00, 4'h0, 18'h0, 1'b0);
    endtask

    task automatic do_reset(bit fm);
        @(negedge clk);
        rst_n = 1'b0;
        flow_mode = fm;
        lat = fm ? 1 : 2;
        clk_en = 1'b1;
        {ce1, ce2, ce3} = 3'b000;
        we = 1'b0; adv_ld = 1'b0; byte_en = 2'b00; addr = 4'h0; wdata = 18'h0;
        oe = 1'b1; burst_ilv = 1'b0; sleep = 1'b0;
        oe_v = 1'b1; ilv_v = 1'b0; slp_v = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {rdata_en, rdata}, 19'h0);
        for (int i = 0; i < 4096; i++) begin rv[i] = 1'b0; wv[i] = 1'b0; end
        n = 0; done_idx = -100; last_cke = 1'b1; blast = 0;
        prev_en = 1'b0; prev_d = '0;
        rst_n = 1'b1;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic run_mode(bit fm);
        do_reset(fm);
        cur_tag = "R1";
        idle(2);

        // Full sweep: latency of the selected timing
        cur_tag = fm ? "R3 flow sweep" : "R2 pipe sweep";
        for (int a = 0; a < 16; a++) wr(4'(a), pat(a, 1), 2'b11);
        for (int a = 0; a < 16; a++) rd(4'(a));
        idle(3);

        // Back-to-back write/read to the same and another word
        cur_tag = "R4 back-to-back";
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), pat(a, 2 + a), 2'b11);
            rd(4'(a));
            rd(4'((a + 7) & 15));
        end
        idle(3);

        // Byte lanes and write abort
        cur_tag = "R5/R6 lanes";
        for (int a = 0; a < 16; a++) wr(4'(a), pat(a, 9), 2'(a & 3));
        for (int a = 0; a < 16; a++) rd(4'(a));
        for (int a = 0; a < 4; a++) begin
            wr(4'(a), pat(a, 11), 2'(3 - a));
            rd(4'(a));
        end
        idle(3);

        // Deselect patterns
        cur_tag = "R7 deselect";
        for (int p = 0; p < 7; p++) begin
            cyc(1'b1, 3'(p), 1'b1, 1'b0, 2'b11, 4'(p), 18'h3FFFF, 1'b0);
            cyc(1'b1, 3'(p), 1'b0, 1'b0, 2'b11, 4'(p), 18'h0, 1'b0);
        end
        for (int a = 0; a < 7; a++) rd(4'(a));
        idle(3);

        // Bursts in both orders from every start offset
        for (int il = 0; il < 2; il++) begin
            ilv_v = il[0];
            for (int s = 0; s < 4; s++) begin
                logic [3:0] base;
                base = 4'(il * 8 + 4 + s);
                cur_tag = il ? "R9 interleaved" : "R8/R9 linear";
                wr(base, pat(s, 20 + il), 2'b11);
                for (int k = 1; k < 4; k++)
                    cyc(1'b1, 3'b000, 1'b0, 1'b1, 2'b11, 4'hF, pat(s + k, 20 + il), 1'b0);
                for (int q = 0; q < 4; q++) rd({base[3:2], 2'(q)});
                rd(base);
                for (int k = 1; k < 4; k++)
                    cyc(1'b1, 3'b000, 1'b1, 1'b1, 2'b11, 4'h0, 18'h0, 1'b0);
            end
        end
        ilv_v = 1'b0;
        cur_tag = "R8 advance after deselect";
        idle(1);
        cyc(1'b1, 3'b111, 1'b1, 1'b1, 2'b11, 4'h4, 18'h3FFFF, 1'b0);
        cyc(1'b1, 3'b111, 1'b0, 1'b1, 2'b11, 4'h4, 18'h0, 1'b0);
        for (int q = 4; q < 8; q++) rd(4'(q));
        idle(3);

        // Stalls inside a mixed stream with junk inputs
        cur_tag = "R10 stall stream";
        for (int i = 0; i < 12; i++) begin
            if (i % 2 == 0) wr(4'(i), pat(i, 30), 2'b11);
            else rd(4'(i - 1));
            if (i % 3 != 2) cyc(1'b0, 3'b111, 1'b1, 1'b0, 2'b11, 4'(15 - i), 18'h15555, 1'b0);
            if (i % 4 == 1) cyc(1'b0, 3'b111, 1'b0, 1'b1, 2'b10, 4'(i), 18'h0AAAA, 1'b0);
        end
        idle(3);

        // Output enable masks reads
        cur_tag = "R12 oe";
        oe_v = 1'b0;
        rd(4'h0); rd(4'h1); rd(4'h2);
        oe_v = 1'b1;
        rd(4'h3); rd(4'h4);
        oe_v = 1'b0;
        idle(1);
        oe_v = 1'b1;
        idle(3);

        // Sleep entry and exit windows
        cur_tag = "R11 sleep";
        wr(4'h5, pat(5, 40), 2'b11);
        idle(3);
        slp_v = 1'b1;
        idle(1);
        wr(4'h6, pat(6, 41), 2'b11);
        for (int i = 0; i < 3; i++) cyc(1'b1, 3'b111, 1'b1, 1'b0, 2'b11, 4'h5, 18'h3FFFF, 1'b1);
        cyc(1'b1, 3'b111, 1'b0, 1'b0, 2'b11, 4'h5, 18'h0, 1'b1);
        slp_v = 1'b0;
        cyc(1'b1, 3'b111, 1'b1, 1'b0, 2'b11, 4'h5, 18'h3FFFF, 1'b1);
        cyc(1'b1, 3'b111, 1'b1, 1'b0, 2'b11, 4'h5, 18'h3FFFF, 1'b1);
        rd(4'h5);
        rd(4'h6);
        idle(4);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        clk_en = 1'b1;
        {ce1, ce2, ce3} = 3'b000;
        we = 1'b0; adv_ld = 1'b0; byte_en = 2'b00; addr = 4'h0; wdata = 18'h0;
        flow_mode = 1'b0; burst_ilv = 1'b0; oe = 1'b1; sleep = 1'b0;
        run_mode(1'b0);
        run_mode(1'b1);
        finish_up();
    end

endmodule